// File: doc/BRIEF.md
# Glitch-Safe Display Clock Source Switch Sequencer

This block moves the 3-bit source selects of two display-clock multiplexers to new values without ever letting a glitch reach the divider behind them. Each multiplexer is built as two 4-input stages that share the low select bits, followed by a 2-input stage that chooses between them on the top select bit. Switching straight between two inputs of the upper stage is unsafe. The sequencer therefore parks a channel on the lower stage, changes the shared low bits while that stage is selected, and only then returns to the upper stage.

A start pulse captures the current shared control word, the two requested targets and two status inputs. The block then works out a four-value path for each channel. If anything moves, it disables the source that has no clock gate and writes the three new control-word values. Between writes it leaves a programmable number of quiet cycles. Afterwards it brings the ungated source back. Every disable, restore and write step uses a request/acknowledge handshake. The block ends with a one-cycle done pulse. Per-channel error and warning flags stay valid until the next start.

Top module: `clksel_switch_seq`

## Requirements
- R1: Channel 0's select sits in control-word bits [11:9] and channel 1's in bits [14:12]. Each write carries both channels, and every other bit of the word captured at start is written back unchanged.
- R2: A channel moving from current select C to accepted target T is written as C|4, then T|4, then T, in that order. No write takes a channel directly from one upper-stage code (0 to 3) to a different upper-stage code.
- R3: A channel whose target equals its current select, or whose request is rejected, carries its current select in all three writes.
- R4: If no channel moves, the block issues no source step and no write, and still produces the done pulse.
- R5: When the memory-clock-busy input is high and a channel's current or target select equals 2, that channel's error flag is set and the channel is held.
- R6: A target above 4 is rejected, and so is a target of 0 while the early-revision input is high. A rejected target sets the channel's error flag and holds the channel.
- R7: A channel's warning flag is set when its current select at start differs from the power-on value 3.
- R8: When anything moves, the source steps run in a fixed order around the three writes. op_code 0 (move the ungated source's consumer to the alternate clock) and then op_code 1 (put the alternate clock into bypass) run before the first write. op_code 2 (take it out of bypass) and then op_code 3 (move the consumer back) run after the last write. A source step and a write are never requested together.
- R9: A write or source request stays high, with stable data and code, until its acknowledge. The next step starts only after that acknowledge.
- R10: Between two successive writes, wr_req stays low for at least GAP_CYC cycles (default 4).
- R11: busy rises the cycle after an accepted start and stays high through a one-cycle done pulse. A start that arrives while busy is ignored, including one in the done cycle.
- R12: After reset, busy, done, wr_req, op_req, err and warn are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse; ignored while busy |
| sel_tgt0 | input | 3 | Requested select for channel 0 |
| sel_tgt1 | input | 3 | Requested select for channel 1 |
| early_rev | input | 1 | Early silicon revision; target 0 is not allowed |
| src2_locked | input | 1 | Source at code 2 is in use as the memory clock |
| ctl_word | input | CW | Shadow copy of the shared control word |
| wr_req | output | 1 | Control-word write request |
| wr_data | output | CW | Control-word value to write |
| wr_ack | input | 1 | Write acknowledge |
| op_req | output | 1 | Source disable/restore request |
| op_code | output | 2 | 0 consumer to alternate, 1 bypass on, 2 bypass off, 3 consumer back |
| op_ack | input | 1 | Source step acknowledge |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 2 | Per-channel rejection flag |
| warn | output | 2 | Per-channel not-at-power-on-value flag |

## Verification
Two events can land on the same clock edge: a fresh start pulse and the sequencer's own completion, or a start and any acknowledge in the middle of a run. The bench provokes this in two ways. It pulses start with different targets part-way through a run, and it pulses start again exactly in the cycle where done is high. It then judges the result by two things: the logged writes and flags still match the first request, and no write or source step appears in the quiet cycles that follow. The acknowledge latency is varied from zero to several cycles, so acknowledges also coincide with gap counting and with request issue.

// File: rtl/clksel_seq_pkg.sv
package clksel_seq_pkg;

  localparam int SEL_W = 3;

  typedef enum logic [1:0] {
    OP_TO_ALT  = 2'd0,
    OP_BYP_ON  = 2'd1,
    OP_BYP_OFF = 2'd2,
    OP_TO_MAIN = 2'd3
  } step_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PLAN,
    ST_OP,
    ST_WR,
    ST_GAP,
    ST_DONE
  } seq_st_e;

  typedef struct packed {
    logic [SEL_W-1:0] hop1;
    logic [SEL_W-1:0] hop2;
    logic [SEL_W-1:0] hop3;
  } sel_path_t;

endpackage

// File: rtl/clksel_path_plan.sv
module clksel_path_plan
  import clksel_seq_pkg::*;
#(
  parameter int HOME_SEL    = 3,
  parameter int LOCK_SEL    = 2,
  parameter int MAX_SEL     = 4,
  parameter int REV_BAD_SEL = 0
) (
  input  logic [SEL_W-1:0] cur_sel,
  input  logic [SEL_W-1:0] tgt_sel,
  input  logic             early_rev,
  input  logic             src2_locked,
  output sel_path_t        path,
  output logic             moves,
  output logic             reject,
  output logic             off_home
);

  localparam logic [SEL_W-1:0] PARK   = {1'b1, {(SEL_W-1){1'b0}}};
  localparam logic [SEL_W-1:0] HOME_L = SEL_W'(HOME_SEL);
  localparam logic [SEL_W-1:0] LOCK_L = SEL_W'(LOCK_SEL);
  localparam logic [SEL_W-1:0] MAX_L  = SEL_W'(MAX_SEL);
  localparam logic [SEL_W-1:0] REV_L  = SEL_W'(REV_BAD_SEL);

  logic             out_of_range;
  logic             rev_refused;
  logic             gate_blocked;
  logic [SEL_W-1:0] eff_tgt;

  always_comb begin
    out_of_range = tgt_sel > MAX_L;
    rev_refused  = early_rev && (tgt_sel == REV_L);
    gate_blocked = src2_locked && ((cur_sel == LOCK_L) || (tgt_sel == LOCK_L));
    reject       = out_of_range || rev_refused || gate_blocked;
    eff_tgt      = reject ? cur_sel : tgt_sel;
    moves        = eff_tgt != cur_sel;
    off_home     = cur_sel != HOME_L;
    path.hop1    = moves ? (cur_sel | PARK) : cur_sel;
    path.hop2    = moves ? (eff_tgt | PARK) : cur_sel;
    path.hop3    = eff_tgt;
  end

  always_comb begin
    if (moves) begin
      AST_PATH_PARKED: assert (path.hop1[SEL_W-1] && path.hop2[SEL_W-1])
        else $error("moving path leaves lower stage early"); // R2
    end
  end

endmodule

// File: rtl/clksel_gap_timer.sv
module clksel_gap_timer #(
  parameter int GAP_CYC = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic arm,
  output logic ready
);

  localparam int GW = $clog2(GAP_CYC + 1);
  localparam logic [GW-1:0] GAP_L = GW'(GAP_CYC);

  logic [GW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (arm) begin
      cnt_q <= GAP_L;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign ready = (cnt_q == '0);

  AST_GAP_ARMED: assert property (@(posedge clk) disable iff (rst)
    arm |=> !ready)
    else $error("gap timer ready right after arming"); // R10

endmodule

// File: rtl/clksel_switch_seq.sv
module clksel_switch_seq
  import clksel_seq_pkg::*;
#(
  parameter int CW          = 32,
  parameter int SEL0_LSB    = 9,
  parameter int SEL1_LSB    = 12,
  parameter int GAP_CYC     = 4,
  parameter int HOME_SEL    = 3,
  parameter int LOCK_SEL    = 2,
  parameter int MAX_SEL     = 4,
  parameter int REV_BAD_SEL = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [SEL_W-1:0] sel_tgt0,
  input  logic [SEL_W-1:0] sel_tgt1,
  input  logic             early_rev,
  input  logic             src2_locked,
  input  logic [CW-1:0]    ctl_word,
  output logic             wr_req,
  output logic [CW-1:0]    wr_data,
  input  logic             wr_ack,
  output logic             op_req,
  output logic [1:0]       op_code,
  input  logic             op_ack,
  output logic             busy,
  output logic             done,
  output logic [1:0]       err,
  output logic [1:0]       warn
);

  localparam int NCH = 2;
  localparam int GW  = $clog2(GAP_CYC + 1);
  localparam logic [GW-1:0] GAP_L = GW'(GAP_CYC);

  function automatic int lsb_of(input int ch);
    return (ch == 0) ? SEL0_LSB : SEL1_LSB;
  endfunction

  seq_st_e          st_q;
  logic [CW-1:0]    snap_q;
  logic [CW-1:0]    applied_q;
  logic [SEL_W-1:0] tgt_q [NCH];
  logic             rev_q;
  logic             lock_q;
  sel_path_t        path_q [NCH];
  logic [1:0]       op_idx_q;
  logic [1:0]       wr_idx_q;
  logic             wr_req_q;
  logic [CW-1:0]    wr_data_q;
  logic             op_req_q;
  step_op_e         op_code_q;
  logic             busy_q;
  logic             done_q;
  logic [NCH-1:0]   err_q;
  logic [NCH-1:0]   warn_q;
  logic [GW-1:0]    since_wr_q;

  sel_path_t        path_w [NCH];
  logic [NCH-1:0]   moves_w;
  logic [NCH-1:0]   rej_w;
  logic [NCH-1:0]   off_w;
  logic [CW-1:0]    wr_word;
  logic             gap_arm;
  logic             gap_ready;

  // Per-channel planning from the captured word
  for (genvar g = 0; g < NCH; g++) begin : g_chan
    localparam int LSB = (g == 0) ? SEL0_LSB : SEL1_LSB;

    clksel_path_plan #(
      .HOME_SEL    (HOME_SEL),
      .LOCK_SEL    (LOCK_SEL),
      .MAX_SEL     (MAX_SEL),
      .REV_BAD_SEL (REV_BAD_SEL)
    ) u_plan (
      .cur_sel     (snap_q[LSB +: SEL_W]),
      .tgt_sel     (tgt_q[g]),
      .early_rev   (rev_q),
      .src2_locked (lock_q),
      .path        (path_w[g]),
      .moves       (moves_w[g]),
      .reject      (rej_w[g]),
      .off_home    (off_w[g])
    );

    AST_NO_DIRECT_HOP: assert property (@(posedge clk) disable iff (rst)
      $rose(wr_req_q) |-> (wr_data_q[LSB+SEL_W-1] || applied_q[LSB+SEL_W-1] ||
                           (wr_data_q[LSB +: SEL_W] == applied_q[LSB +: SEL_W])))
      else $error("upper-stage to upper-stage select change"); // R2
  end

  // Control word for the current write step
  always_comb begin
    wr_word = snap_q;
    for (int c = 0; c < NCH; c++) begin
      case (wr_idx_q)
        2'd0:    wr_word[lsb_of(c) +: SEL_W] = path_q[c].hop1;
        2'd1:    wr_word[lsb_of(c) +: SEL_W] = path_q[c].hop2;
        default: wr_word[lsb_of(c) +: SEL_W] = path_q[c].hop3;
      endcase
    end
  end

  assign gap_arm = (st_q == ST_WR) && wr_req_q && wr_ack && (wr_idx_q != 2'd2);

  clksel_gap_timer #(
    .GAP_CYC (GAP_CYC)
  ) u_gap (
    .clk   (clk),
    .rst   (rst),
    .arm   (gap_arm),
    .ready (gap_ready)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= ST_IDLE;
      snap_q    <= '0;
      applied_q <= '0;
      rev_q     <= 1'b0;
      lock_q    <= 1'b0;
      op_idx_q  <= '0;
      wr_idx_q  <= '0;
      wr_req_q  <= 1'b0;
      wr_data_q <= '0;
      op_req_q  <= 1'b0;
      op_code_q <= OP_TO_ALT;
      busy_q    <= 1'b0;
      done_q    <= 1'b0;
      err_q     <= '0;
      warn_q    <= '0;
      for (int c = 0; c < NCH; c++) begin
        tgt_q[c]  <= '0;
        path_q[c] <= '0;
      end
    end else begin
      done_q <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          if (start && !busy_q) begin
            busy_q    <= 1'b1;
            snap_q    <= ctl_word;
            applied_q <= ctl_word;
            tgt_q[0]  <= sel_tgt0;
            tgt_q[1]  <= sel_tgt1;
            rev_q     <= early_rev;
            lock_q    <= src2_locked;
            err_q     <= '0;
            warn_q    <= '0;
            st_q      <= ST_PLAN;
          end
        end
        ST_PLAN: begin
          for (int c = 0; c < NCH; c++) path_q[c] <= path_w[c];
          err_q    <= rej_w;
          warn_q   <= off_w;
          op_idx_q <= '0;
          wr_idx_q <= '0;
          if (|moves_w) begin
            st_q <= ST_OP;
          end else begin
            done_q <= 1'b1;
            st_q   <= ST_DONE;
          end
        end
        ST_OP: begin
          if (!op_req_q) begin
            op_req_q  <= 1'b1;
            op_code_q <= step_op_e'(op_idx_q);
          end else if (op_ack) begin
            op_req_q <= 1'b0;
            op_idx_q <= op_idx_q + 2'd1;
            if (op_idx_q == 2'd1) begin
              st_q <= ST_WR;
            end else if (op_idx_q == 2'd3) begin
              done_q <= 1'b1;
              st_q   <= ST_DONE;
            end
          end
        end
        ST_WR: begin
          if (!wr_req_q) begin
            wr_req_q  <= 1'b1;
            wr_data_q <= wr_word;
          end else if (wr_ack) begin
            wr_req_q  <= 1'b0;
            applied_q <= wr_data_q;
            wr_idx_q  <= wr_idx_q + 2'd1;
            st_q      <= (wr_idx_q == 2'd2) ? ST_OP : ST_GAP;
          end
        end
        ST_GAP: begin
          if (gap_ready) st_q <= ST_WR;
        end
        ST_DONE: begin
          busy_q <= 1'b0;
          st_q   <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // Quiet-cycle counter seen by the write-spacing check
  always_ff @(posedge clk) begin
    if (rst) begin
      since_wr_q <= '0;
    end else if (wr_req_q && wr_ack) begin
      since_wr_q <= '0;
    end else if (!wr_req_q && (since_wr_q < GAP_L)) begin
      since_wr_q <= since_wr_q + 1'b1;
    end
  end

  assign wr_req  = wr_req_q;
  assign wr_data = wr_data_q;
  assign op_req  = op_req_q;
  assign op_code = op_code_q;
  assign busy    = busy_q;
  assign done    = done_q;
  assign err     = err_q;
  assign warn    = warn_q;

  AST_ONE_REQ: assert property (@(posedge clk) disable iff (rst)
    !(wr_req_q && op_req_q))
    else $error("write and source step requested together"); // R8

  AST_GATE_BEFORE_WR: assert property (@(posedge clk) disable iff (rst)
    ($rose(wr_req_q) && (wr_idx_q == 2'd0)) |-> (op_idx_q == 2'd2))
    else $error("first write before both disable steps"); // R8

  AST_WR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (wr_req_q && !wr_ack) |=> (wr_req_q && $stable(wr_data_q)))
    else $error("write request dropped or changed before ack"); // R9

  AST_OP_HOLD: assert property (@(posedge clk) disable iff (rst)
    (op_req_q && !op_ack) |=> (op_req_q && $stable(op_code_q)))
    else $error("source request dropped or changed before ack"); // R9

  AST_WR_SPACING: assert property (@(posedge clk) disable iff (rst)
    ($rose(wr_req_q) && (wr_idx_q != 2'd0)) |-> (since_wr_q >= GAP_L))
    else $error("writes too close together"); // R10

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q)
    else $error("done longer than one cycle"); // R11

  AST_DONE_IN_BUSY: assert property (@(posedge clk) disable iff (rst)
    done_q |-> busy_q)
    else $error("done outside busy"); // R11

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !busy_q |-> (!wr_req_q && !op_req_q))
    else $error("request while not busy"); // R11

endmodule

// File: tb/clksel_switch_seq_bench.sv
`timescale 1ns/1ps
module clksel_switch_seq_bench;

  localparam int CW  = 32;
  localparam int GAP = 4;
  localparam int L0  = 9;
  localparam int L1  = 12;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [2:0]    sel_tgt0 = '0;
  logic [2:0]    sel_tgt1 = '0;
  logic          early_rev = 1'b0;
  logic          src2_locked = 1'b0;
  logic [CW-1:0] ctl_word = '0;
  logic          wr_req;
  logic [CW-1:0] wr_data;
  logic          wr_ack = 1'b0;
  logic          op_req;
  logic [1:0]    op_code;
  logic          op_ack = 1'b0;
  logic          busy;
  logic          done;
  logic [1:0]    err;
  logic [1:0]    warn;

  int checks = 0;
  int fails  = 0;

  // handshake responder and activity log
  int            dly = 0;
  int            wr_cnt = 0, op_cnt = 0;
  logic [CW-1:0] wr_log [8];
  int            op_log [8];
  int            op_at  [8];
  int            wr_low = 0, gap_min = 1000, drops = 0;
  int            wcnt = 0, ocnt = 0;
  logic          wr_prev = 1'b0, op_prev = 1'b0;

  always #4 clk = ~clk;

  clksel_switch_seq #(.CW(CW), .SEL0_LSB(L0), .SEL1_LSB(L1), .GAP_CYC(GAP)) u_clksel_switch_seq (
    .clk(clk), .rst(rst), .start(start), .sel_tgt0(sel_tgt0), .sel_tgt1(sel_tgt1),
    .early_rev(early_rev), .src2_locked(src2_locked), .ctl_word(ctl_word),
    .wr_req(wr_req), .wr_data(wr_data), .wr_ack(wr_ack),
    .op_req(op_req), .op_code(op_code), .op_ack(op_ack),
    .busy(busy), .done(done), .err(err), .warn(warn));

  always @(negedge clk) begin
    logic wa, oa;
    wa = wr_ack;
    oa = op_ack;
    if (wr_prev && !wr_req && !wa) drops++;
    if (op_prev && !op_req && !oa) drops++;
    if (wa) begin
      if (wr_cnt < 8) wr_log[wr_cnt] = wr_data;
      wr_cnt++;
      wr_ack = 1'b0;
      wcnt = 0;
      wr_low = 0;
    end else if (wr_req) begin
      if (!wr_prev && wr_cnt > 0 && wr_low < gap_min) gap_min = wr_low;
      if (wcnt >= dly) wr_ack = 1'b1; else wcnt++;
    end else begin
      wcnt = 0;
      wr_low++;
    end
    if (oa) begin
      if (op_cnt < 8) begin op_log[op_cnt] = int'(op_code); op_at[op_cnt] = wr_cnt; end
      op_cnt++;
      op_ack = 1'b0;
      ocnt = 0;
    end else if (op_req) begin
      if (ocnt >= dly) op_ack = 1'b1; else ocnt++;
    end else begin
      ocnt = 0;
    end
    wr_prev = wr_req;
    op_prev = op_req;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [CW-1:0] put(input logic [CW-1:0] w, input int lsb, input logic [2:0] v);
    logic [CW-1:0] r;
    r = w;
    r[lsb +: 3] = v;
    return r;
  endfunction

  // expected path from the requirements
  task automatic exp_path(input logic [2:0] c, input logic [2:0] t, input bit rev, input bit lock,
                          output logic [2:0] s [3], output bit e, output bit w, output bit mv);
    logic [2:0] te;
    e  = (t > 3'd4) || (rev && t == 3'd0) || (lock && (c == 3'd2 || t == 3'd2));
    w  = (c != 3'd3);
    te = e ? c : t;
    mv = (te != c);
    s[0] = mv ? (c | 3'd4) : c;
    s[1] = mv ? (te | 3'd4) : c;
    s[2] = te;
  endtask

  task automatic run_case(input logic [CW-1:0] base, input logic [2:0] c0, input logic [2:0] c1,
                          input logic [2:0] t0, input logic [2:0] t1, input bit rev, input bit lock,
                          input int d, input int poke);
    logic [CW-1:0] ctl;
    logic [2:0] p0 [3];
    logic [2:0] p1 [3];
    bit e0, e1, w0, w1, m0, m1, any;
    int cyc;
    int wr_snap;
    ctl = put(put(base, L0, c0), L1, c1);
    exp_path(c0, t0, rev, lock, p0, e0, w0, m0);
    exp_path(c1, t1, rev, lock, p1, e1, w1, m1);
    any = m0 || m1;
    @(negedge clk);
    dly = d; wr_cnt = 0; op_cnt = 0; gap_min = 1000; drops = 0; wr_low = 0;
    ctl_word = ctl; sel_tgt0 = t0; sel_tgt1 = t1; early_rev = rev; src2_locked = lock;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R11 busy after start", 32'(busy), 32'd1);
    cyc = 0;
    while (!done && cyc < 3000) begin
      @(negedge clk);
      start = 1'b0;
      cyc++;
      if (poke == 1 && cyc == 6) begin
        start = 1'b1; sel_tgt0 = 3'd1; sel_tgt1 = 3'd2; ctl_word = ~ctl;
      end
    end
    chk(done == 1'b1, "R11 done seen", 32'(done), 32'd1);
    chk(err == {e1, e0}, "R5 R6 err flags", 32'(err), 32'({e1, e0}));
    chk(warn == {w1, w0}, "R7 warn flags", 32'(warn), 32'({w1, w0}));
    if (poke == 2) start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(done == 1'b0, "R11 done one cycle", 32'(done), 32'd0);
    if (any) begin
      chk(wr_cnt == 3, "R2 write count", 32'(wr_cnt), 32'd3);
      for (int k = 0; k < 3; k++) begin
        logic [CW-1:0] ew;
        ew = put(put(ctl, L0, p0[k]), L1, p1[k]);
        chk(wr_log[k] == ew, "R1 R2 R3 write word", wr_log[k], ew);
      end
      chk(op_cnt == 4, "R8 source step count", 32'(op_cnt), 32'd4);
      for (int k = 0; k < 4; k++) begin
        chk(op_log[k] == k, "R8 source step code", 32'(op_log[k]), 32'(k));
        chk(op_at[k] == ((k < 2) ? 0 : 3), "R8 step placement", 32'(op_at[k]), 32'((k < 2) ? 0 : 3));
      end
      chk(gap_min >= GAP, "R10 write spacing", 32'(gap_min), 32'(GAP));
      chk(drops == 0, "R9 request held to ack", 32'(drops), 32'd0);
    end else begin
      chk(wr_cnt == 0, "R4 no writes", 32'(wr_cnt), 32'd0);
      chk(op_cnt == 0, "R4 no source steps", 32'(op_cnt), 32'd0);
    end
    wr_snap = wr_cnt;
    repeat (30) @(negedge clk);
    chk(busy == 1'b0, "R11 busy released", 32'(busy), 32'd0);
    chk(wr_cnt == wr_snap, "R11 no activity after done", 32'(wr_cnt), 32'(wr_snap));
  endtask

  task automatic t_reset();
    chk(busy == 0 && done == 0, "R12 busy/done at reset", 32'({busy, done}), 32'd0);
    chk(wr_req == 0 && op_req == 0, "R12 requests at reset", 32'({wr_req, op_req}), 32'd0);
    chk(err == 0 && warn == 0, "R12 flags at reset", 32'({err, warn}), 32'd0);
  endtask

  task automatic t_both_move();    run_case(32'hDEAD_81F5, 3'd3, 3'd3, 3'd0, 3'd1, 1'b0, 1'b0, 2, 0); endtask
  task automatic t_one_move();     run_case(32'hFFFF_FFFF, 3'd3, 3'd3, 3'd3, 3'd4, 1'b0, 1'b0, 0, 0); endtask
  task automatic t_no_move();      run_case(32'h1234_5678, 3'd3, 3'd3, 3'd3, 3'd3, 1'b0, 1'b0, 1, 0); endtask
  task automatic t_locked();       run_case(32'h0000_0000, 3'd2, 3'd3, 3'd1, 3'd0, 1'b0, 1'b1, 1, 0); endtask
  task automatic t_lock_tgt();     run_case(32'hA5A5_A5A5, 3'd3, 3'd3, 3'd2, 3'd1, 1'b0, 1'b1, 0, 0); endtask
  task automatic t_unlocked_two(); run_case(32'h0F0F_0F0F, 3'd2, 3'd3, 3'd1, 3'd2, 1'b0, 1'b0, 3, 0); endtask
  task automatic t_invalid();      run_case(32'h5555_AAAA, 3'd3, 3'd3, 3'd6, 3'd0, 1'b1, 1'b0, 1, 0); endtask
  task automatic t_rev_other();    run_case(32'hC3C3_3C3C, 3'd3, 3'd1, 3'd0, 3'd4, 1'b0, 1'b0, 2, 0); endtask
  task automatic t_off_home();     run_case(32'h8000_0001, 3'd5, 3'd3, 3'd1, 3'd7, 1'b0, 1'b0, 0, 0); endtask
  task automatic t_busy_mid();     run_case(32'h7777_7777, 3'd3, 3'd3, 3'd4, 3'd0, 1'b0, 1'b0, 2, 1); endtask
  task automatic t_done_poke();    run_case(32'h0000_FFFF, 3'd3, 3'd3, 3'd1, 3'd1, 1'b0, 1'b0, 0, 2); endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_both_move();
    t_one_move();
    t_no_move();
    t_locked();
    t_lock_tgt();
    t_unlocked_two();
    t_invalid();
    t_rev_other();
    t_off_home();
    t_busy_mid();
    t_done_poke();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 150000);
    checks++;
    fails++;
    $display("FAIL R11 watchdog expired: actual running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule